// File: doc/BRIEF.md
# Display Sink Discovery Sequencer

This block runs the start-up discovery of a display sink over an abstract auxiliary channel. It is started by a one-cycle pulse and reads the sink's capability bytes one at a time. It checks the revision, the maximum link rate and the maximum lane count, and derives the enhanced-frame flag. It then reads the sink's display identification data over the channel's I2C path. Each 128-byte block is checked with a modulo-256 checksum. A second block is read when the extension count is nonzero.

At the end it reads the sink's test-request register. If the sink has asked for an identification-data read test, the block writes back the checksum byte of the last block and then the response flag. The channel sees one request at a time, each a single byte, with a valid/ready handshake and a response that carries data and an error flag. When the sequence ends, the block holds either a done level with the selected rate code, lane count and enhanced-frame flag, or an error level with an error code.

Top module: `sink_discovery`

## Requirements
- R1: A `start` pulse while idle, done or failed begins a new sequence and clears `done`, `error` and `errCode`. A `start` pulse during a sequence is ignored. `done` and `error` are levels, never both high, and `errCode` is 0 whenever `done` is high.
- R2: At most one request is outstanding. `reqValid` stays high with stable `reqAddr`/`reqWdata` until `reqReady`. No new request is raised before the response (`rspValid`) of the previous one.
- R3: The capability phase issues 12 native single-byte reads (`reqI2c`=0, `reqWrite`=0) at addresses 0x000 to 0x00B in ascending order.
- R4: A response with `rspErr` during the capability phase restarts that phase from address 0x000. At most 5 attempts are made. A failure in the fifth attempt ends with `errCode`=5.
- R5: Capability byte 0 (revision) must be 0x10 or 0x11, else `errCode`=1. This check takes priority over R6 and R7.
- R6: Capability byte 1 (maximum rate) must be 0x06 or 0x0A, else `errCode`=2. This check takes priority over R7.
- R7: Capability byte 2 gives the lane count. For revision 0x11 the lane count is bits 4:0 and `enhFrame` is bit 7. For revision 0x10 the lane count is the whole byte and `enhFrame` is 0. Only 1, 2 or 4 is accepted, else `errCode`=3.
- R8: Identification reads use `reqI2c`=1 with device address 0x50 in `reqAddr[14:8]` and the byte offset in `reqAddr[7:0]`. The first read is offset 0x7E. Then offsets 0x00 to 0x7F are read in order, and 0x80 to 0xFF follow when the byte at 0x7E was nonzero.
- R9: Each 128-byte block must sum to 0 modulo 256, else the sequence stops with `errCode`=4.
- R10: After the blocks, a native read of 0x218 is made. If its bit 1 is set, a native write of the last block's final byte (offset 0x7F or 0xFF) to 0x261 is followed by a write of 0x04 to 0x260. If bit 1 is clear, no write is made.
- R11: A response with `rspErr` outside the capability phase ends the sequence at once, without retry, with `errCode`=5.
- R12: While `done` is high, `linkRate` holds capability byte 1, and `laneCount` and `enhFrame` hold the values accepted under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins discovery |
| reqValid | output | 1 | Channel request valid |
| reqReady | input | 1 | Channel accepts the request |
| reqWrite | output | 1 | 1 = byte write, 0 = byte read |
| reqI2c | output | 1 | 1 = I2C path, 0 = native register path |
| reqAddr | output | 20 | Native address, or {device, offset} for I2C |
| reqWdata | output | 8 | Write byte |
| rspValid | input | 1 | One-cycle response strobe |
| rspData | input | 8 | Read byte |
| rspErr | input | 1 | Request failed |
| done | output | 1 | Discovery finished successfully |
| error | output | 1 | Discovery failed |
| errCode | output | 3 | 0 none, 1 revision, 2 rate, 3 lanes, 4 checksum, 5 channel |
| linkRate | output | 8 | Accepted maximum rate code |
| laneCount | output | 5 | Accepted lane count |
| enhFrame | output | 1 | Enhanced-frame capability |

## Verification
The response that carries byte 127 of a block does two things in the same cycle. It completes the running checksum, and it is latched as the byte later written back in the test response. If the capture were late or early, a wrong byte would go out even though the block check passes. The bench provokes this with an extended two-block image and the test bit set. It then checks that the block passes and that the byte written to 0x261 equals the image's byte at offset 0xFF, and for a one-block image the byte at 0x7F. A second meeting point is a channel error on the final permitted capability attempt. There the retry decision and the failure exit compete, and the bench judges it by counting attempts at address 0x000 under four and under five injected failures.

// File: rtl/disc_pkg.sv
package disc_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_NODEV = 3'd1,
    ERR_RATE  = 3'd2,
    ERR_LANES = 3'd3,
    ERR_SUM   = 3'd4,
    ERR_CHAN  = 3'd5
  } errCode_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic     clrIdx;
    logic     incIdx;
    logic     clrTry;
    logic     incTry;
    logic     capStore;
    logic     extStore;
    logic     clrSum;
    logic     sumAdd;
    logic     chkStore;
    logic     incBlk;
    logic     clrBlk;
    logic     setErr;
    errCode_e errVal;
  } strobe_t;

  localparam logic [7:0] REV_10     = 8'h10;
  localparam logic [7:0] REV_11     = 8'h11;
  localparam logic [7:0] RATE_LOW   = 8'h06;
  localparam logic [7:0] RATE_HIGH  = 8'h0A;
  localparam logic [6:0] EDID_DEV   = 7'h50;
  localparam logic [7:0] EDID_EXT   = 8'h7E;
  localparam int         TREQ_ADDR  = 'h218;
  localparam int         TRSP_ADDR  = 'h260;
  localparam int         TCHK_ADDR  = 'h261;
  localparam int         TREQ_BIT   = 1;
  localparam logic [7:0] TRSP_FLAG  = 8'h04;

endpackage

// File: rtl/disc_dpath.sv
module disc_dpath
  import disc_pkg::*;
#(
  parameter int CapBytes = 12,
  parameter int CapTries = 5,
  parameter int BlkBytes = 128,
  localparam int IdxW = $clog2(BlkBytes),
  localparam int TryW = $clog2(CapTries + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [7:0]      rspData,
  output logic [IdxW-1:0] idx,
  output logic            blk,
  output logic            capLast,
  output logic            blkByteLast,
  output logic            triesOut,
  output logic            blkLast,
  output logic            sumZero,
  output errCode_e        capErr,
  output logic [7:0]      lastChk,
  output logic [7:0]      linkRate,
  output logic [4:0]      laneCount,
  output logic            enhFrame,
  output errCode_e        errCode
);

  logic [TryW-1:0] tryCnt;
  logic [7:0]      sum;
  logic [7:0]      revByte;
  logic [7:0]      rateByte;
  logic [7:0]      laneByte;
  logic            extMulti;
  logic [7:0]      laneVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      blk      <= 1'b0;
      tryCnt   <= '0;
      sum      <= '0;
      revByte  <= '0;
      rateByte <= '0;
      laneByte <= '0;
      extMulti <= 1'b0;
      lastChk  <= '0;
      errCode  <= ERR_NONE;
    end else begin
      if (stb.clrIdx)      idx <= '0;
      else if (stb.incIdx) idx <= idx + 1'b1;

      if (stb.clrBlk)      blk <= 1'b0;
      else if (stb.incBlk) blk <= 1'b1;

      if (stb.clrTry)      tryCnt <= '0;
      else if (stb.incTry) tryCnt <= tryCnt + 1'b1;

      if (stb.clrSum)      sum <= '0;
      else if (stb.sumAdd) sum <= sum + rspData;

      if (stb.capStore) begin
        if (idx == IdxW'(0)) revByte  <= rspData;
        if (idx == IdxW'(1)) rateByte <= rspData;
        if (idx == IdxW'(2)) laneByte <= rspData;
      end

      if (stb.extStore) extMulti <= (rspData != 8'h00);
      if (stb.chkStore) lastChk  <= rspData;
      if (stb.setErr)   errCode  <= stb.errVal;
    end
  end

  assign capLast     = (idx == IdxW'(CapBytes - 1));
  assign blkByteLast = (idx == IdxW'(BlkBytes - 1));
  assign triesOut    = (tryCnt == TryW'(CapTries - 1));
  assign blkLast     = (blk == extMulti);
  assign sumZero     = (sum == 8'h00);

  // lane field width depends on the revision
  assign laneVal = (revByte == REV_11) ? {3'b000, laneByte[4:0]} : laneByte;

  always_comb begin
    if (revByte != REV_10 && revByte != REV_11)                  capErr = ERR_NODEV;
    else if (rateByte != RATE_LOW && rateByte != RATE_HIGH)      capErr = ERR_RATE;
    else if (laneVal != 8'd1 && laneVal != 8'd2 && laneVal != 8'd4) capErr = ERR_LANES;
    else                                                         capErr = ERR_NONE;
  end

  assign linkRate  = rateByte;
  assign laneCount = laneVal[4:0];
  assign enhFrame  = (revByte == REV_11) && laneByte[7];

  // R4
  // attempt counter never passes the last permitted attempt
  try_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt < TryW'(CapTries));

endmodule

// File: rtl/disc_ctrl.sv
module disc_ctrl
  import disc_pkg::*;
#(
  parameter int AddrW    = 20,
  parameter int BlkBytes = 128,
  localparam int IdxW = $clog2(BlkBytes)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             reqValid,
  input  logic             reqReady,
  output logic             reqWrite,
  output logic             reqI2c,
  output logic [AddrW-1:0] reqAddr,
  output logic [7:0]       reqWdata,
  input  logic             rspValid,
  input  logic [7:0]       rspData,
  input  logic             rspErr,
  input  logic [IdxW-1:0]  idx,
  input  logic             blk,
  input  logic             capLast,
  input  logic             blkByteLast,
  input  logic             triesOut,
  input  logic             blkLast,
  input  logic             sumZero,
  input  errCode_e         capErr,
  input  logic [7:0]       lastChk,
  output strobe_t          stb,
  output logic             done,
  output logic             error
);

  typedef enum logic [4:0] {
    S_IDLE, S_CAP_REQ, S_CAP_WAIT, S_CAP_CHK,
    S_EXT_REQ, S_EXT_WAIT, S_BLK_REQ, S_BLK_WAIT, S_BLK_CHK,
    S_TRQ_REQ, S_TRQ_WAIT, S_TCK_REQ, S_TCK_WAIT,
    S_TRS_REQ, S_TRS_WAIT, S_DONE, S_FAIL
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      S_IDLE, S_DONE, S_FAIL: if (start) begin
        nxt = S_CAP_REQ;
        stb.clrIdx = 1'b1;
        stb.clrTry = 1'b1;
        stb.setErr = 1'b1;
        stb.errVal = ERR_NONE;
      end
      S_CAP_REQ: if (reqReady) nxt = S_CAP_WAIT;
      S_CAP_WAIT: if (rspValid) begin
        if (rspErr) begin
          if (triesOut) begin
            nxt = S_FAIL; stb.setErr = 1'b1; stb.errVal = ERR_CHAN;
          end else begin
            nxt = S_CAP_REQ; stb.incTry = 1'b1; stb.clrIdx = 1'b1;
          end
        end else begin
          stb.capStore = 1'b1;
          if (capLast) nxt = S_CAP_CHK;
          else begin nxt = S_CAP_REQ; stb.incIdx = 1'b1; end
        end
      end
      S_CAP_CHK: begin
        if (capErr != ERR_NONE) begin
          nxt = S_FAIL; stb.setErr = 1'b1; stb.errVal = capErr;
        end else nxt = S_EXT_REQ;
      end
      S_EXT_REQ: if (reqReady) nxt = S_EXT_WAIT;
      S_EXT_WAIT: if (rspValid) begin
        if (rspErr) begin
          nxt = S_FAIL; stb.setErr = 1'b1; stb.errVal = ERR_CHAN;
        end else begin
          nxt = S_BLK_REQ;
          stb.extStore = 1'b1; stb.clrIdx = 1'b1;
          stb.clrBlk = 1'b1;   stb.clrSum = 1'b1;
        end
      end
      S_BLK_REQ: if (reqReady) nxt = S_BLK_WAIT;
      S_BLK_WAIT: if (rspValid) begin
        if (rspErr) begin
          nxt = S_FAIL; stb.setErr = 1'b1; stb.errVal = ERR_CHAN;
        end else begin
          stb.sumAdd = 1'b1;
          if (blkByteLast) begin nxt = S_BLK_CHK; stb.chkStore = 1'b1; end
          else begin nxt = S_BLK_REQ; stb.incIdx = 1'b1; end
        end
      end
      S_BLK_CHK: begin
        if (!sumZero) begin
          nxt = S_FAIL; stb.setErr = 1'b1; stb.errVal = ERR_SUM;
        end else if (blkLast) nxt = S_TRQ_REQ;
        else begin
          nxt = S_BLK_REQ;
          stb.incBlk = 1'b1; stb.clrIdx = 1'b1; stb.clrSum = 1'b1;
        end
      end
      S_TRQ_REQ: if (reqReady) nxt = S_TRQ_WAIT;
      S_TRQ_WAIT: if (rspValid) begin
        if (rspErr) begin
          nxt = S_FAIL; stb.setErr = 1'b1; stb.errVal = ERR_CHAN;
        end else nxt = rspData[TREQ_BIT] ? S_TCK_REQ : S_DONE;
      end
      S_TCK_REQ: if (reqReady) nxt = S_TCK_WAIT;
      S_TCK_WAIT: if (rspValid) begin
        if (rspErr) begin
          nxt = S_FAIL; stb.setErr = 1'b1; stb.errVal = ERR_CHAN;
        end else nxt = S_TRS_REQ;
      end
      S_TRS_REQ: if (reqReady) nxt = S_TRS_WAIT;
      S_TRS_WAIT: if (rspValid) begin
        if (rspErr) begin
          nxt = S_FAIL; stb.setErr = 1'b1; stb.errVal = ERR_CHAN;
        end else nxt = S_DONE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  // request field generation
  always_comb begin
    reqValid = 1'b0;
    reqWrite = 1'b0;
    reqI2c   = 1'b0;
    reqAddr  = '0;
    reqWdata = '0;
    unique case (state)
      S_CAP_REQ: begin
        reqValid = 1'b1;
        reqAddr  = AddrW'(idx);
      end
      S_EXT_REQ: begin
        reqValid = 1'b1; reqI2c = 1'b1;
        reqAddr  = AddrW'({EDID_DEV, EDID_EXT});
      end
      S_BLK_REQ: begin
        reqValid = 1'b1; reqI2c = 1'b1;
        reqAddr  = AddrW'({EDID_DEV, 8'h00}) + AddrW'(blk) * AddrW'(BlkBytes) + AddrW'(idx);
      end
      S_TRQ_REQ: begin
        reqValid = 1'b1;
        reqAddr  = AddrW'(TREQ_ADDR);
      end
      S_TCK_REQ: begin
        reqValid = 1'b1; reqWrite = 1'b1;
        reqAddr  = AddrW'(TCHK_ADDR);
        reqWdata = lastChk;
      end
      S_TRS_REQ: begin
        reqValid = 1'b1; reqWrite = 1'b1;
        reqAddr  = AddrW'(TRSP_ADDR);
        reqWdata = TRSP_FLAG;
      end
      default: ;
    endcase
  end

  assign done  = (state == S_DONE);
  assign error = (state == S_FAIL);

  // R2
  // a stalled request keeps its fields until accepted
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqWdata) && $stable(reqWrite)));

  // R1
  // completion levels are exclusive
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

endmodule

// File: rtl/sink_discovery.sv
module sink_discovery
  import disc_pkg::*;
#(
  parameter int AddrW    = 20,
  parameter int CapBytes = 12,
  parameter int CapTries = 5,
  parameter int BlkBytes = 128,
  localparam int IdxW = $clog2(BlkBytes)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             reqValid,
  input  logic             reqReady,
  output logic             reqWrite,
  output logic             reqI2c,
  output logic [AddrW-1:0] reqAddr,
  output logic [7:0]       reqWdata,
  input  logic             rspValid,
  input  logic [7:0]       rspData,
  input  logic             rspErr,
  output logic             done,
  output logic             error,
  output logic [2:0]       errCode,
  output logic [7:0]       linkRate,
  output logic [4:0]       laneCount,
  output logic             enhFrame
);

  strobe_t         stb;
  logic [IdxW-1:0] idx;
  logic            blk, capLast, blkByteLast, triesOut, blkLast, sumZero;
  errCode_e        capErr, errCodeE;
  logic [7:0]      lastChk;

  disc_ctrl #(.AddrW(AddrW), .BlkBytes(BlkBytes)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqI2c(reqI2c), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .idx(idx), .blk(blk), .capLast(capLast), .blkByteLast(blkByteLast),
    .triesOut(triesOut), .blkLast(blkLast), .sumZero(sumZero),
    .capErr(capErr), .lastChk(lastChk), .stb(stb),
    .done(done), .error(error)
  );

  disc_dpath #(.CapBytes(CapBytes), .CapTries(CapTries), .BlkBytes(BlkBytes)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .rspData(rspData),
    .idx(idx), .blk(blk), .capLast(capLast), .blkByteLast(blkByteLast),
    .triesOut(triesOut), .blkLast(blkLast), .sumZero(sumZero),
    .capErr(capErr), .lastChk(lastChk), .linkRate(linkRate),
    .laneCount(laneCount), .enhFrame(enhFrame), .errCode(errCodeE)
  );

  assign errCode = errCodeE;

  // R12
  // a finished sequence always reports a legal lane count
  lanes_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (laneCount == 5'd1 || laneCount == 5'd2 || laneCount == 5'd4));

  // R1
  // entering failure always carries a nonzero code; success carries zero
  fail_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> (errCode != 3'd0));

  // R1
  done_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCode == 3'd0));

endmodule

// File: tb/sim_sink_discovery.sv
`timescale 1ns/100ps
module sim_sink_discovery;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        reqValid, reqWrite, reqI2c;
  logic        reqReady = 1'b1;
  logic [19:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        rspValid = 1'b0;
  logic [7:0]  rspData = 8'h00;
  logic        rspErr = 1'b0;
  logic        done, error, enhFrame;
  logic [2:0]  errCode;
  logic [7:0]  linkRate;
  logic [4:0]  laneCount;

  always #2.5 clk = ~clk;

  sink_discovery u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqI2c(reqI2c), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .done(done), .error(error), .errCode(errCode),
    .linkRate(linkRate), .laneCount(laneCount), .enhFrame(enhFrame)
  );

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  // sink model state
  logic [7:0] capMem [12];
  logic [7:0] edid [256];
  logic [7:0] testReq;
  int  capFails, capStarts, expCap, expOfs, i2cReads, i2cFailAt, seqBad, overlapBad;
  int  wCnt;
  int  wAddr [4];
  int  wData [4];
  bit  pending = 0;
  bit  pW, pI;
  logic [19:0] pA;
  logic [7:0]  pD;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic serve();
    rspValid = 1'b1;
    rspData  = 8'h00;
    if (pW) begin
      if (wCnt < 4) begin wAddr[wCnt] = int'(pA); wData[wCnt] = int'(pD); end
      wCnt++;
    end else if (!pI) begin
      if (pA < 20'd12) begin
        if (int'(pA) != expCap) seqBad++;
        if (pA == 20'd0) capStarts++;
        if (pA == 20'd5 && capFails > 0) begin
          capFails--; rspErr = 1'b1; expCap = 0;
        end else begin
          rspData = capMem[int'(pA)];
          expCap = (pA == 20'd11) ? 0 : int'(pA) + 1;
        end
      end else if (pA == 20'h218) rspData = testReq;
    end else begin
      i2cReads++;
      if (pA[14:8] != 7'h50) rspErr = 1'b1;
      else if (i2cReads == 1) begin
        if (pA[7:0] != 8'h7E) seqBad++;
        rspData = edid[126];
      end else begin
        if (int'(pA[7:0]) != expOfs) seqBad++;
        expOfs++;
        rspData = edid[int'(pA[7:0])];
      end
      if (i2cFailAt == i2cReads) rspErr = 1'b1;
    end
  endtask

  // channel responder: accepts at a falling edge, answers at the next one
  initial begin
    forever begin
      @(negedge clk);
      rspValid = 1'b0;
      rspErr   = 1'b0;
      if (pending) begin
        if (reqValid) overlapBad++;
        pending = 0;
        serve();
      end else if (reqValid && reqReady) begin
        pending = 1;
        pW = reqWrite; pI = reqI2c; pA = reqAddr; pD = reqWdata;
      end
    end
  end

  task automatic fillEdid(input int ext, input int seed);
    logic [7:0] s0, s1;
    s0 = 8'h00; s1 = 8'h00;
    for (int i = 0; i < 256; i++) edid[i] = 8'(i * 3 + seed);
    edid[126] = 8'(ext);
    for (int i = 0; i < 127; i++) s0 = s0 + edid[i];
    edid[127] = 8'h00 - s0;
    for (int i = 128; i < 255; i++) s1 = s1 + edid[i];
    edid[255] = 8'h00 - s1;
  endtask

  task automatic prep(input logic [7:0] rev, input logic [7:0] rate,
                      input logic [7:0] lane, input int ext, input logic [7:0] trq);
    for (int i = 0; i < 12; i++) capMem[i] = 8'(8'hA0 + i);
    capMem[0] = rev; capMem[1] = rate; capMem[2] = lane;
    testReq = trq;
    fillEdid(ext, 17);
    capFails = 0; capStarts = 0; expCap = 0; expOfs = 0;
    i2cReads = 0; i2cFailAt = 0; seqBad = 0; overlapBad = 0; wCnt = 0;
  endtask

  task automatic run();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (done || error) break;
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset error", int'(error), 0);
    chk("R2 reset reqValid", int'(reqValid), 0);
  endtask

  task automatic tBasic();
    prep(8'h11, 8'h0A, 8'h84, 0, 8'h00);
    run();
    chk("R1 basic done", int'(done), 1);
    chk("R1 basic code", int'(errCode), 0);
    chk("R12 basic rate", int'(linkRate), 'h0A);
    chk("R7 basic lanes", int'(laneCount), 4);
    chk("R7 basic enh", int'(enhFrame), 1);
    chk("R3 basic attempts", capStarts, 1);
    chk("R3 R8 basic order", seqBad, 0);
    chk("R2 basic overlap", overlapBad, 0);
    chk("R8 basic i2c reads", i2cReads, 129);
    chk("R10 basic no writes", wCnt, 0);
  endtask

  task automatic tTwoBlocksTest();
    prep(8'h10, 8'h06, 8'h02, 1, 8'h02);
    run();
    chk("R1 ext done", int'(done), 1);
    chk("R12 ext rate", int'(linkRate), 'h06);
    chk("R7 rev10 lanes", int'(laneCount), 2);
    chk("R7 rev10 enh", int'(enhFrame), 0);
    chk("R8 ext i2c reads", i2cReads, 257);
    chk("R8 ext order", seqBad, 0);
    chk("R10 ext write count", wCnt, 2);
    chk("R10 ext chk addr", wAddr[0], 'h261);
    chk("R10 ext chk byte", wData[0], int'(edid[255]));
    chk("R10 ext rsp addr", wAddr[1], 'h260);
    chk("R10 ext rsp flag", wData[1], 4);
  endtask

  task automatic tOneBlockTest();
    prep(8'h11, 8'h06, 8'h01, 0, 8'h03);
    run();
    chk("R1 one done", int'(done), 1);
    chk("R7 one lanes", int'(laneCount), 1);
    chk("R7 one enh", int'(enhFrame), 0);
    chk("R10 one write count", wCnt, 2);
    chk("R10 one chk byte", wData[0], int'(edid[127]));
    chk("R10 one rsp flag", wData[1], 4);
  endtask

  task automatic tCapErrors();
    prep(8'h12, 8'h14, 8'h03, 0, 8'h00);
    run();
    chk("R5 bad rev error", int'(error), 1);
    chk("R5 bad rev priority", int'(errCode), 1);
    chk("R5 no edid after rev fail", i2cReads, 0);
    prep(8'h11, 8'h14, 8'h03, 0, 8'h00);
    run();
    chk("R6 bad rate code", int'(errCode), 2);
    prep(8'h11, 8'h0A, 8'h03, 0, 8'h00);
    run();
    chk("R7 three lanes code", int'(errCode), 3);
    prep(8'h10, 8'h0A, 8'h82, 0, 8'h00);
    run();
    chk("R7 rev10 whole byte code", int'(errCode), 3);
    prep(8'h11, 8'h0A, 8'h82, 0, 8'h00);
    run();
    chk("R7 rev11 masked ok", int'(done), 1);
    chk("R7 rev11 masked lanes", int'(laneCount), 2);
  endtask

  task automatic tChecksum();
    prep(8'h11, 8'h0A, 8'h04, 0, 8'h00);
    edid[10] = edid[10] ^ 8'h01;
    run();
    chk("R9 block0 bad code", int'(errCode), 4);
    chk("R9 block0 reads", i2cReads, 129);
    prep(8'h11, 8'h0A, 8'h04, 1, 8'h02);
    edid[200] = edid[200] + 8'h01;
    run();
    chk("R9 block1 bad code", int'(errCode), 4);
    chk("R9 block1 reads", i2cReads, 257);
    chk("R9 block1 no writes", wCnt, 0);
  endtask

  task automatic tRetry();
    prep(8'h11, 8'h0A, 8'h04, 0, 8'h00);
    capFails = 4;
    run();
    chk("R4 four fails done", int'(done), 1);
    chk("R4 four fails attempts", capStarts, 5);
    chk("R4 restart order", seqBad, 0);
    prep(8'h11, 8'h0A, 8'h04, 0, 8'h00);
    capFails = 5;
    run();
    chk("R4 five fails code", int'(errCode), 5);
    chk("R4 five fails attempts", capStarts, 5);
    chk("R4 five fails no edid", i2cReads, 0);
  endtask

  task automatic tChanErr();
    prep(8'h11, 8'h0A, 8'h04, 1, 8'h00);
    i2cFailAt = 40;
    run();
    chk("R11 i2c fail code", int'(errCode), 5);
    chk("R11 no retry", i2cReads, 40);
    chk("R11 capability once", capStarts, 1);
  endtask

  task automatic tStartBusy();
    prep(8'h11, 8'h0A, 8'h04, 0, 8'h00);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (done || error) break;
      @(negedge clk);
    end
    chk("R1 busy start ignored", capStarts, 1);
    chk("R1 busy start done", int'(done), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tBasic();
    tTwoBlocksTest();
    tOneBlockTest();
    tCapErrors();
    tChecksum();
    tRetry();
    tChanErr();
    tStartBusy();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule